// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers thirteen level-sensitive peripheral interrupt lines into one 4-bit interrupt level for the processor. Each line is sampled into its own bit of a 16-bit monitor word. Software masks that word through a 16-bit register. The encoder then picks the surviving source with the numerically smallest level and drives that level, inverted, toward the processor.

A small 16-bit register window sits beside the encoder. It holds the mask register, a general-purpose output latch, a constant version word and a power-off register. A write to the power-off register with bit 0 set produces a one-cycle shutdown request.

Top module: `irq_level_encoder`

## Requirements
- R1: Each input `irq_in[i]` is sampled every clock into a fixed monitor bit. The bit is set while the line is high and clear while it is low. Input index = priority level. The monitor bits for levels 0..12 are 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Monitor bits 1..3 are always 0.
- R2: A source takes part in arbitration only when its monitor bit and the same bit of the mask register are both 1.
- R3: Among the sources taking part, the one with the smallest level wins. With none taking part, the level is 15.
- R4: `irl_code` equals the winning level XOR 15. No source therefore gives 0, and level 0 gives 15.
- R5: Writing byte offset 0x00 loads the mask register, and writing 0x36 loads the output latch. Reads of those offsets return the stored values. The output latch also drives `out_port`.
- R6: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R7: Offset 0x30 reads 0. A write there with bit 0 set pulses `shutdown_req` high for exactly the next clock cycle. A write there with bit 0 clear produces no pulse.
- R8: Reads of any other offset, odd offsets included, return 0. Writes to such offsets change neither the mask register, the output latch nor `shutdown_req`.
- R9: `irl_code` reflects an input change or a mask write one clock edge after that change is sampled, and not earlier.
- R10: While reset is asserted, the mask, the output latch, the monitor word and `shutdown_req` are all 0, so `irl_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 13 | Peripheral interrupt lines, index = priority level |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 6 | Byte offset into the 0x40-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irl_code | output | 4 | Inverted winning interrupt level |
| out_port | output | 16 | Output latch contents |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
A corrupted monitor or mask bit shows up one clock later as a wrong `irl_code`, but only while the affected source would win the arbitration. Corrupted mask state also shows up at once on a read of offset 0x00. For that reason the stimulus holds several sources high at the same time, so that each one in turn becomes the winner. A wrong mapping between input and monitor bit shows up as a code that belongs to a different level, so every line is exercised both alone and with lower-priority neighbours active. A decode fault shows up either at `bus_rdata` on the same cycle or as a stray `shutdown_req` one clock after the write.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int NUM_SRC  = 13;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int LVL_W    = 4;
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWROFF  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VERSION = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_OUTPORT = 6'h36;
  localparam logic [DATA_W-1:0] VERSION_VAL = 16'h0010;

  // monitor/mask bit position owned by the source of a given level
  function automatic logic [3:0] src_bit(input int lvl);
    case (lvl)
      0:  src_bit = 4'd11;
      1:  src_bit = 4'd9;
      2:  src_bit = 4'd8;
      3:  src_bit = 4'd12;
      4:  src_bit = 4'd10;
      5:  src_bit = 4'd6;
      6:  src_bit = 4'd5;
      7:  src_bit = 4'd4;
      8:  src_bit = 4'd7;
      9:  src_bit = 4'd14;
      10: src_bit = 4'd13;
      11: src_bit = 4'd0;
      default: src_bit = 4'd15;
    endcase
  endfunction

  // smallest level whose bit is active; IDLE_LVL when none
  function automatic logic [LVL_W-1:0] pick_level(input logic [DATA_W-1:0] act);
    logic [LVL_W-1:0] lvl;
    lvl = IDLE_LVL;
    for (int l = NUM_SRC - 1; l >= 0; l--) begin
      if (act[src_bit(l)]) lvl = LVL_W'(l);
    end
    return lvl;
  endfunction
endpackage

// File: rtl/irl_monitor.sv
module irl_monitor
  import irl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  output logic [W-1:0]     monitor_q
);
  logic [W-1:0] mon_next;

  always_comb begin
    mon_next = '0;
    for (int i = 0; i < N_SRC; i++) begin
      mon_next[src_bit(i)] = irq_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) monitor_q <= '0;
    else        monitor_q <= mon_next;
  end
endmodule

// File: rtl/irl_regfile.sv
module irl_regfile
  import irl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int W  = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  outport_q,
  output logic          shutdown_q,
  output logic          mask_wr,
  output logic          pwroff_hit
);
  logic outport_wr;

  assign mask_wr    = bus_wr && (bus_addr == OFS_MASK);
  assign outport_wr = bus_wr && (bus_addr == OFS_OUTPORT);
  assign pwroff_hit = bus_wr && (bus_addr == OFS_PWROFF) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      outport_q  <= '0;
      shutdown_q <= 1'b0;
    end else begin
      if (mask_wr)    mask_q    <= bus_wdata;
      if (outport_wr) outport_q <= bus_wdata;
      shutdown_q <= pwroff_hit;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK:    bus_rdata = mask_q;
      OFS_OUTPORT: bus_rdata = outport_q;
      OFS_VERSION: bus_rdata = VERSION_VAL;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
  import irl_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int LW = LVL_W
) (
  input  logic [W-1:0]  monitor_q,
  input  logic [W-1:0]  mask_q,
  output logic [W-1:0]  active_vec,
  output logic [LW-1:0] win_level,
  output logic [LW-1:0] code
);
  assign active_vec = monitor_q & mask_q;
  assign win_level  = pick_level(active_vec);
  assign code       = win_level ^ IDLE_LVL;
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int W     = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [LW-1:0]    irl_code,
  output logic [W-1:0]     out_port,
  output logic             shutdown_req
);
  logic [W-1:0]  monitor_q;
  logic [W-1:0]  mask_q;
  logic [W-1:0]  active_vec;
  logic [LW-1:0] win_level;
  logic          mask_wr;
  logic          pwroff_hit;

  irl_monitor #(.N_SRC(N_SRC), .W(W)) u_mon (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .monitor_q(monitor_q)
  );

  irl_regfile #(.AW(AW), .W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mask_q(mask_q),
    .outport_q(out_port), .shutdown_q(shutdown_req), .mask_wr(mask_wr),
    .pwroff_hit(pwroff_hit)
  );

  irl_prio_enc #(.W(W), .LW(LW)) u_enc (
    .monitor_q(monitor_q), .mask_q(mask_q), .active_vec(active_vec),
    .win_level(win_level), .code(irl_code)
  );
endmodule

// File: rtl/irl_chk.sv
module irl_chk
  import irl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LVL_W-1:0]  irl_code,
  input logic              shutdown_req,
  input logic [DATA_W-1:0] active_vec,
  input logic [DATA_W-1:0] mask_q,
  input logic              mask_wr,
  input logic              pwroff_hit
);
  // R7
  shutdown_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(pwroff_hit));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vec == '0) |-> (irl_code == '0));

  // R3
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_code != '0) |-> active_vec[src_bit(int'(irl_code ^ IDLE_LVL))]);

  // R6
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VERSION) |-> (bus_rdata == VERSION_VAL));

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFS_MASK && bus_addr != OFS_OUTPORT && bus_addr != OFS_VERSION)
      |-> (bus_rdata == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(bus_wdata)));

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_vec & ~mask_q) == '0));
endmodule

bind irq_level_encoder irl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irl_code(irl_code), .shutdown_req(shutdown_req),
  .active_vec(active_vec), .mask_q(mask_q), .mask_wr(mask_wr),
  .pwroff_hit(pwroff_hit)
);

// File: tb/irq_level_encoder_tb.sv
module irq_level_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_code;
  logic [15:0] out_port;
  logic        shutdown_req;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  irq_level_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irl_code(irl_code), .out_port(out_port), .shutdown_req(shutdown_req)
  );

  // level owned by each monitor bit, -1 = unused
  int bit_lvl [16];
  initial begin
    bit_lvl = '{11, -1, -1, -1, 7, 6, 5, 8, 2, 1, 4, 0, 3, 10, 9, 12};
  end

  // reference model state
  logic [15:0] m_mask, m_out, m_seen;
  logic        m_sd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= 0; m_out <= 0; m_seen <= 0; m_sd <= 0;
    end else begin
      logic [15:0] s;
      s = 0;
      for (int b = 0; b < 16; b++)
        if (bit_lvl[b] >= 0) s[b] = irq_in[bit_lvl[b]];
      m_seen <= s;
      if (bus_wr && bus_addr == 6'h00) m_mask <= bus_wdata;
      if (bus_wr && bus_addr == 6'h36) m_out <= bus_wdata;
      m_sd <= bus_wr && bus_addr == 6'h30 && bus_wdata[0];
    end
  end

  function automatic int ref_code(input logic [15:0] seen, input logic [15:0] msk);
    int best;
    best = 15;
    for (int b = 0; b < 16; b++)
      if (seen[b] && msk[b] && bit_lvl[b] >= 0 && bit_lvl[b] < best) best = bit_lvl[b];
    return best ^ 15;
  endfunction

  function automatic logic [15:0] ref_read(input logic [5:0] a);
    case (a)
      6'h00:   return m_mask;
      6'h36:   return m_out;
      6'h32:   return 16'h0010;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 irl_code", int'(irl_code), ref_code(m_seen, m_mask));
      chk("R5 out_port", int'(out_port), int'(m_out));
      chk("R7 shutdown_req", int'(shutdown_req), int'(m_sd));
      chk("R8 bus_rdata", int'(bus_rdata), int'(ref_read(bus_addr)));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic set_irq(input logic [12:0] v);
    @(posedge clk); #1;
    irq_in = v;
  endtask

  task automatic settle;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset code", int'(irl_code), 0);
    chk("R10 reset shutdown", int'(shutdown_req), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R10 post-reset mask read", int'(bus_rdata), 0);

    wr(6'h00, 16'hFFFF);
    // R9: change sampled at the next edge, not earlier
    set_irq(13'h0200);            // level 9 alone
    @(negedge clk);
    chk("R9 before edge", int'(irl_code), 0);
    @(negedge clk);
    chk("R1 level 9 alone", int'(irl_code), 6);

    set_irq(13'h0201);            // level 0 also
    settle();
    chk("R3 lowest wins", int'(irl_code), 15);

    wr(6'h00, 16'hF7FF);          // clear bit 11 (level 0)
    @(negedge clk);
    chk("R2 masked level 0", int'(irl_code), 6);

    set_irq(13'h1000);            // level 12 alone
    settle();
    chk("R4 level 12 code", int'(irl_code), 3);

    set_irq(13'h0000);
    settle();
    chk("R3 none active", int'(irl_code), 0);

    wr(6'h32, 16'hBEEF);
    bus_addr = 6'h32;
    @(negedge clk);
    chk("R6 version after write", int'(bus_rdata), 16'h0010);

    wr(6'h36, 16'hA5C3);
    bus_addr = 6'h36;
    @(negedge clk);
    chk("R5 outport read", int'(bus_rdata), 16'hA5C3);
    chk("R5 outport pin", int'(out_port), 16'hA5C3);

    wr(6'h10, 16'h0001);
    wr(6'h01, 16'h0000);
    bus_addr = 6'h00;
    @(negedge clk);
    chk("R8 mask untouched", int'(bus_rdata), 16'hF7FF);
    chk("R8 outport untouched", int'(out_port), 16'hA5C3);

    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 16'h0001;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    @(negedge clk);
    chk("R7 pulse high", int'(shutdown_req), 1);
    @(negedge clk);
    chk("R7 pulse single", int'(shutdown_req), 0);
    wr(6'h30, 16'hFFFE);
    bus_addr = 6'h30;
    @(negedge clk);
    chk("R7 bit0 clear no pulse", int'(shutdown_req), 0);
    chk("R7 read zero", int'(bus_rdata), 0);

    // each source alone, then with every lower-priority one active
    wr(6'h00, 16'hFFFF);
    for (int l = 0; l < 13; l++) begin
      set_irq(13'(1) << l);
      settle();
      chk("R1 single source", int'(irl_code), 15 ^ l);
      set_irq(~((13'(1) << l) - 13'd1));
      settle();
      chk("R3 with lower ones", int'(irl_code), 15 ^ l);
    end

    // mixed traffic compared each cycle
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      irq_in = 13'($urandom);
      case ($urandom % 8)
        0: begin bus_wr = 1'b1; bus_addr = 6'h00; end
        1: begin bus_wr = 1'b1; bus_addr = 6'h36; end
        2: begin bus_wr = 1'b1; bus_addr = 6'h30; end
        3: begin bus_wr = 1'b1; bus_addr = 6'($urandom); end
        default: begin bus_wr = 1'b0; bus_addr = 6'($urandom); end
      endcase
      bus_wdata = 16'($urandom);
    end
    @(posedge clk); #1;
    bus_wr = 1'b0;

    // R10: reset mid-run
    rst_n = 1'b0;
    #2;
    chk("R10 reset code mid-run", int'(irl_code), 0);
    chk("R10 reset outport", int'(out_port), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule